// File: doc/BRIEF.md
# JTAG Scan Chain Selector

This block is the instruction and data-register side of a JTAG test port. It contains its own 16-state TAP controller, a 4-bit instruction register, a 1-bit bypass register and a chain-number register. It steers the serial test data between TDI and TDO through one of these registers or through one of up to sixteen numbered external scan chains.

The data path for chain accesses is chosen indirectly. A scan-select instruction shifts a chain number into the chain-number register, and Update-DR latches it. That chain then stays latched while other instructions are loaded. Sample/preload and external-test scans then go to the latched chain. For that chain only, the block raises capture, shift and update strobes in the matching controller states. External-test also raises a test-mode level for the chain cells.

A restart instruction behaves exactly like bypass. It also emits a one-cycle debug-exit pulse each time the controller enters Run-Test-Idle.

Top module: `jsel_top`

## Requirements
- R1: The controller follows the standard 16-state TAP graph on TMS at the TCK rising edge. Five TCK cycles with TMS high reach Test-Logic-Reset from any state. In that state the instruction returns to bypass and the latched chain returns to the reset chain.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. It captures 4'b0001 in Capture-IR, so the first bits out are 1,0,0,0. The new instruction takes effect on leaving Update-IR.
- R3: The opcodes are 4'b0000 external-test, 4'b0010 scan-select, 4'b0011 sample/preload, 4'b0100 restart and 4'b1111 bypass. Any other opcode behaves as bypass.
- R4: The bypass register is one bit. It captures 0 in Capture-DR, so a bypass scan returns 0 followed by the TDI bits delayed by one cycle.
- R5: Under scan-select, the 4-bit chain-number register sits between TDI and TDO. It shifts least significant bit first and captures 4'b1000 in Capture-DR, giving the bits 0,0,0,1.
- R6: Under scan-select, Update-DR latches the shifted number as the selected chain. `chain_sel` is the one-hot decode of the selected chain. The selection holds across later instructions until the next scan-select Update-DR.
- R7: After TRST_N is asserted, chain 3 is selected and the instruction is bypass.
- R8: Under sample/preload or external-test, TDO carries the selected chain's serial output. `chain_capture`, `chain_shift` and `chain_update` pulse for that chain alone, in Capture-DR, Shift-DR and Update-DR respectively.
- R9: `chain_test` is high while external-test is the current instruction and low otherwise.
- R10: Under restart, the bypass register sits between TDI and TDO. `dbg_exit` is high for exactly the one TCK cycle after each entry into Run-Test-Idle, including entry straight from loading restart.
- R11: TDO and `tdo_oe` update on the TCK falling edge. `tdo_oe` is high only in Shift-DR and Shift-IR, and TDO is 0 whenever `tdo_oe` is low.
- R12: A latched chain number equal to or above NCH selects no chain. No chain strobes fire, and chain scans return 0 on TDO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| chain_so | input | NCH | Serial output of each external chain |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | TDO drive enable |
| chain_sel | output | NCH | One-hot decode of the latched chain |
| chain_capture | output | NCH | Capture strobe per chain |
| chain_shift | output | NCH | Shift strobe per chain |
| chain_update | output | NCH | Update strobe per chain |
| chain_test | output | 1 | Chain cells in test mode (external-test) |
| dbg_exit | output | 1 | One-cycle debug-exit pulse |

## Verification
The bench builds the block with NCH = 6 and the default 4-bit chain number. With those values, numbers 6 to 15 are legal to shift in but name no chain, so the empty-selection behaviour of R12 can be reached. At the default NCH of 16 every code would be a real chain. Six chains are still enough to show a selection moving away from reset chain 3 to chain 5 and persisting across instruction changes. Each modelled chain captures a distinct byte, so the bench can see which chain was routed.

// File: rtl/jsel_pkg.sv
package jsel_pkg;

   localparam int IR_W = 4;

   typedef enum logic [3:0] {
      ST_TLR    = 4'h0,
      ST_RTI    = 4'h1,
      ST_SELDR  = 4'h2,
      ST_CAPDR  = 4'h3,
      ST_SHDR   = 4'h4,
      ST_EX1DR  = 4'h5,
      ST_PADR   = 4'h6,
      ST_EX2DR  = 4'h7,
      ST_UPDR   = 4'h8,
      ST_SELIR  = 4'h9,
      ST_CAPIR  = 4'hA,
      ST_SHIR   = 4'hB,
      ST_EX1IR  = 4'hC,
      ST_PAIR   = 4'hD,
      ST_EX2IR  = 4'hE,
      ST_UPIR   = 4'hF
   } jsel_st_e;

   localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
   localparam logic [IR_W-1:0] OP_SSEL    = 4'b0010;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0011;
   localparam logic [IR_W-1:0] OP_RESTART = 4'b0100;
   localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

   typedef struct packed {
      logic extest;
      logic sample;
      logic ssel;
      logic restart;
   } jsel_dec_t;

endpackage

// File: rtl/jsel_tap.sv
module jsel_tap
   import jsel_pkg::*;
(
   input  logic     tck,
   input  logic     trst_n,
   input  logic     tms,
   output jsel_st_e st,
   output jsel_st_e st_nxt
);

   always_comb begin
      unique case (st)
         ST_TLR:   st_nxt = tms ? ST_TLR   : ST_RTI;
         ST_RTI:   st_nxt = tms ? ST_SELDR : ST_RTI;
         ST_SELDR: st_nxt = tms ? ST_SELIR : ST_CAPDR;
         ST_CAPDR: st_nxt = tms ? ST_EX1DR : ST_SHDR;
         ST_SHDR:  st_nxt = tms ? ST_EX1DR : ST_SHDR;
         ST_EX1DR: st_nxt = tms ? ST_UPDR  : ST_PADR;
         ST_PADR:  st_nxt = tms ? ST_EX2DR : ST_PADR;
         ST_EX2DR: st_nxt = tms ? ST_UPDR  : ST_SHDR;
         ST_UPDR:  st_nxt = tms ? ST_SELDR : ST_RTI;
         ST_SELIR: st_nxt = tms ? ST_TLR   : ST_CAPIR;
         ST_CAPIR: st_nxt = tms ? ST_EX1IR : ST_SHIR;
         ST_SHIR:  st_nxt = tms ? ST_EX1IR : ST_SHIR;
         ST_EX1IR: st_nxt = tms ? ST_UPIR  : ST_PAIR;
         ST_PAIR:  st_nxt = tms ? ST_EX2IR : ST_PAIR;
         ST_EX2IR: st_nxt = tms ? ST_UPIR  : ST_SHIR;
         ST_UPIR:  st_nxt = tms ? ST_SELDR : ST_RTI;
         default:  st_nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= ST_TLR;
      else         st <= st_nxt;
   end

   // R1
   tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR && tms) |=> (st == ST_TLR));

   // R1
   rti_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_RTI && !tms) |=> (st == ST_RTI));

endmodule

// File: rtl/jsel_ireg.sv
module jsel_ireg
   import jsel_pkg::*;
(
   input  logic      tck,
   input  logic      trst_n,
   input  logic      tdi,
   input  jsel_st_e  st,
   output logic      ir_bit,
   output jsel_dec_t dec,
   output logic      restart_eff
);

   logic [IR_W-1:0] ir_sh;
   logic [IR_W-1:0] ir_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= '0;
         ir_q  <= OP_BYPASS;
      end else begin
         unique case (st)
            ST_TLR:   ir_q  <= OP_BYPASS;
            ST_CAPIR: ir_sh <= IR_CAPTURE;
            ST_SHIR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            ST_UPIR:  ir_q  <= ir_sh;
            default:  ;
         endcase
      end
   end

   always_comb begin
      dec         = '0;
      dec.extest  = (ir_q == OP_EXTEST);
      dec.sample  = (ir_q == OP_SAMPLE);
      dec.ssel    = (ir_q == OP_SSEL);
      dec.restart = (ir_q == OP_RESTART);
   end

   assign ir_bit      = ir_sh[0];
   assign restart_eff = (st == ST_UPIR) ? (ir_sh == OP_RESTART) : dec.restart;

   // R2
   ir_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAPIR) |=> (ir_sh == IR_CAPTURE));

   // R1
   ir_tlr_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR) |=> (ir_q == OP_BYPASS));

endmodule

// File: rtl/jsel_dreg.sv
module jsel_dreg
   import jsel_pkg::*;
#(
   parameter int SEL_W       = 4,
   parameter int RESET_CHAIN = 3
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tdi,
   input  jsel_st_e         st,
   input  logic             ssel,
   output logic             byp_bit,
   output logic             ssr_bit,
   output logic [SEL_W-1:0] sel
);

   localparam logic [SEL_W-1:0] SSR_CAP = SEL_W'(1) << (SEL_W - 1);
   localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(RESET_CHAIN);

   logic             byp_q;
   logic [SEL_W-1:0] ssr_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q <= 1'b0;
      end else if (st == ST_CAPDR) begin
         byp_q <= 1'b0;
      end else if (st == ST_SHDR) begin
         byp_q <= tdi;
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ssr_q <= '0;
         sel   <= SEL_RST;
      end else if (st == ST_TLR) begin
         sel   <= SEL_RST;
      end else if (ssel) begin
         unique case (st)
            ST_CAPDR: ssr_q <= SSR_CAP;
            ST_SHDR:  ssr_q <= {tdi, ssr_q[SEL_W-1:1]};
            ST_UPDR:  sel   <= ssr_q;
            default:  ;
         endcase
      end
   end

   assign byp_bit = byp_q;
   assign ssr_bit = ssr_q[0];

   // R4
   byp_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAPDR) |=> !byp_q);

   // R5
   ssr_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAPDR && ssel) |=> (ssr_q == SSR_CAP));

   // R6
   sel_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st != ST_TLR && !(st == ST_UPDR && ssel)) |=> $stable(sel));

endmodule

// File: rtl/jsel_top.sv
module jsel_top
   import jsel_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int SEL_W       = 4,
   parameter int RESET_CHAIN = 3
) (
   input  logic           tck,
   input  logic           tms,
   input  logic           tdi,
   input  logic           trst_n,
   input  logic [NCH-1:0] chain_so,
   output logic           tdo,
   output logic           tdo_oe,
   output logic [NCH-1:0] chain_sel,
   output logic [NCH-1:0] chain_capture,
   output logic [NCH-1:0] chain_shift,
   output logic [NCH-1:0] chain_update,
   output logic           chain_test,
   output logic           dbg_exit
);

   if (SEL_W < 2 || SEL_W > 8) begin : g_bad_selw
      $error("jsel_top: SEL_W out of range");
   end
   if (NCH < 1 || NCH > (1 << SEL_W)) begin : g_bad_nch
      $error("jsel_top: NCH exceeds chain number space");
   end
   if (RESET_CHAIN < 0 || RESET_CHAIN >= (1 << SEL_W)) begin : g_bad_rst
      $error("jsel_top: RESET_CHAIN not encodable");
   end

   jsel_st_e         st;
   jsel_st_e         st_nxt;
   jsel_dec_t        dec;
   logic             ir_bit;
   logic             restart_eff;
   logic             byp_bit;
   logic             ssr_bit;
   logic [SEL_W-1:0] sel;
   logic             chain_path;
   logic             chain_bit;
   logic             dr_bit;
   logic             tdo_d;
   logic             dbg_q;

   jsel_tap u_tap (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st),
      .st_nxt (st_nxt)
   );

   jsel_ireg u_ireg (
      .tck         (tck),
      .trst_n      (trst_n),
      .tdi         (tdi),
      .st          (st),
      .ir_bit      (ir_bit),
      .dec         (dec),
      .restart_eff (restart_eff)
   );

   jsel_dreg #(
      .SEL_W       (SEL_W),
      .RESET_CHAIN (RESET_CHAIN)
   ) u_dreg (
      .tck     (tck),
      .trst_n  (trst_n),
      .tdi     (tdi),
      .st      (st),
      .ssel    (dec.ssel),
      .byp_bit (byp_bit),
      .ssr_bit (ssr_bit),
      .sel     (sel)
   );

   assign chain_path = dec.extest | dec.sample;
   assign chain_test = dec.extest;

   logic [NCH-1:0] so_hit;

   for (genvar k = 0; k < NCH; k++) begin : g_chain
      assign chain_sel[k]     = (sel == SEL_W'(k));
      assign chain_capture[k] = chain_path & chain_sel[k] & (st == ST_CAPDR);
      assign chain_shift[k]   = chain_path & chain_sel[k] & (st == ST_SHDR);
      assign chain_update[k]  = chain_path & chain_sel[k] & (st == ST_UPDR);
      assign so_hit[k]        = chain_sel[k] & chain_so[k];
   end

   assign chain_bit = |so_hit;

   always_comb begin
      if (dec.ssel)       dr_bit = ssr_bit;
      else if (chain_path) dr_bit = chain_bit;
      else                dr_bit = byp_bit;
   end

   always_comb begin
      unique case (st)
         ST_SHIR: tdo_d = ir_bit;
         ST_SHDR: tdo_d = dr_bit;
         default: tdo_d = 1'b0;
      endcase
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= tdo_d;
         tdo_oe <= (st == ST_SHIR) || (st == ST_SHDR);
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) dbg_q <= 1'b0;
      else         dbg_q <= restart_eff && (st_nxt == ST_RTI) && (st != ST_RTI);
   end

   assign dbg_exit = dbg_q;

   // R10
   dbg_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
      dbg_exit |=> !dbg_exit);

   // R10
   dbg_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
      dbg_exit |-> (st == ST_RTI));

   // R11
   tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_oe |-> !tdo);

   // R8
   cap_then_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (|chain_capture) |=> (st == ST_SHDR || st == ST_EX1DR));

   // R12
   empty_sel_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (chain_sel == '0) |-> (chain_shift == '0 && chain_capture == '0));

endmodule

// File: tb/sim_jsel_top.sv
module sim_jsel_top;

   localparam int NCH = 6;

   logic           tck = 1'b0;
   logic           tms = 1'b1;
   logic           tdi = 1'b0;
   logic           trst_n = 1'b0;
   logic [NCH-1:0] chain_so;
   logic           tdo;
   logic           tdo_oe;
   logic [NCH-1:0] chain_sel;
   logic [NCH-1:0] chain_capture;
   logic [NCH-1:0] chain_shift;
   logic [NCH-1:0] chain_update;
   logic           chain_test;
   logic           dbg_exit;

   always #4 tck = ~tck;

   jsel_top #(.NCH(NCH)) u0 (
      .tck           (tck),
      .tms           (tms),
      .tdi           (tdi),
      .trst_n        (trst_n),
      .chain_so      (chain_so),
      .tdo           (tdo),
      .tdo_oe        (tdo_oe),
      .chain_sel     (chain_sel),
      .chain_capture (chain_capture),
      .chain_shift   (chain_shift),
      .chain_update  (chain_update),
      .chain_test    (chain_test),
      .dbg_exit      (dbg_exit)
   );

   // external chain models: each captures 0xA0+k, shifts LSB first
   logic [7:0] cmod [NCH];
   always @(posedge tck) begin
      for (int k = 0; k < NCH; k++) begin
         if (chain_capture[k])    cmod[k] <= 8'hA0 + 8'(k);
         else if (chain_shift[k]) cmod[k] <= {tdi, cmod[k][7:1]};
      end
   end
   always_comb for (int k = 0; k < NCH; k++) chain_so[k] = cmod[k][0];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   typedef struct {
      logic  v;
      string tag;
   } exp_t;
   exp_t expq[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compares TDO bits against the expected queue
   always begin
      @(negedge tck);
      #2;
      if (tdo_oe) begin
         if (expq.size() == 0) begin
            check(0, "R11 unexpected tdo_oe", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(tdo === e.v, e.tag, int'(tdo), int'(e.v));
         end
      end
   end

   task automatic tick(input logic m, input logic d);
      @(negedge tck);
      #1;
      tms = m;
      tdi = d;
      @(posedge tck);
      #1;
   endtask

   task automatic scan_ir(input logic [3:0] op);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      expq.push_back('{1'b1, "R2 ir capture"});
      expq.push_back('{1'b0, "R2 ir capture"});
      expq.push_back('{1'b0, "R2 ir capture"});
      expq.push_back('{1'b0, "R2 ir capture"});
      for (int i = 0; i < 4; i++) tick(i == 3, op[i]);
      tick(1, 0); tick(0, 0);
   endtask

   task automatic scan_dr(input int n, input logic [15:0] din,
                          input logic [15:0] dexp, input string tag);
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < n; i++) expq.push_back('{dexp[i], tag});
      for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
      tick(1, 0); tick(0, 0);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         check(0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NCH; k++) cmod[k] = 8'h00;
      #20;
      // R7 reset state
      check(chain_sel == 6'b001000, "R7 reset chain", chain_sel, 6'b001000);
      check(!tdo_oe && !dbg_exit, "R11 reset quiet", {tdo_oe, dbg_exit}, 0);
      trst_n = 1'b1;
      tick(0, 0);
      check(tdo_oe == 0 && tdo == 0, "R11 idle tdo", {tdo_oe, tdo}, 0);

      // R4 default instruction is bypass: 0 then delayed tdi
      scan_dr(5, 16'b10110, 16'b01100, "R4 bypass");

      // R8 sample on reset chain 3
      scan_ir(4'b0011);
      check(chain_test == 0, "R9 sample not test", chain_test, 0);
      scan_dr(8, 16'h0055, 16'h00A3, "R8 chain3 data");

      // R5 scan-select: capture 1000, shift in 5
      scan_ir(4'b0010);
      scan_dr(4, 16'h0005, 16'h0008, "R5 ssr capture");
      check(chain_sel == 6'b100000, "R6 latched chain5", chain_sel, 6'b100000);

      // R6 selection persists into sample
      scan_ir(4'b0011);
      check(chain_sel == 6'b100000, "R6 held after ir", chain_sel, 6'b100000);
      scan_dr(8, 16'h00FF, 16'h00A5, "R8 chain5 data");

      // R9 external-test
      scan_ir(4'b0000);
      check(chain_test == 1, "R9 extest level", chain_test, 1);
      scan_dr(8, 16'h0000, 16'h00A5, "R8 extest chain5");

      // R12 out-of-range chain 9
      scan_ir(4'b0010);
      scan_dr(4, 16'h0009, 16'h0008, "R5 ssr capture");
      check(chain_sel == 6'b000000, "R12 no chain", chain_sel, 0);
      scan_ir(4'b0011);
      scan_dr(8, 16'h00FF, 16'h0000, "R12 empty data");

      // R10 restart: pulse on RTI entry
      scan_ir(4'b0100);
      check(dbg_exit == 1, "R10 pulse on load", dbg_exit, 1);
      tick(0, 0);
      check(dbg_exit == 0, "R10 single cycle", dbg_exit, 0);
      scan_dr(3, 16'b101, 16'b010, "R10 restart bypass");
      check(dbg_exit == 1, "R10 pulse after dr", dbg_exit, 1);
      tick(0, 0);

      // R3 unimplemented opcode behaves as bypass
      scan_ir(4'b0111);
      check(dbg_exit == 0, "R3 no pulse", dbg_exit, 0);
      scan_dr(4, 16'b0011, 16'b0110, "R3 unknown bypass");

      // R1 TLR resets instruction and chain
      scan_ir(4'b0010);
      scan_dr(4, 16'h0004, 16'h0008, "R5 ssr capture");
      scan_ir(4'b0011);
      check(chain_sel == 6'b010000, "R6 chain4", chain_sel, 6'b010000);
      for (int i = 0; i < 5; i++) tick(1, 0);
      check(chain_sel == 6'b001000, "R1 tlr chain", chain_sel, 6'b001000);
      tick(0, 0);
      scan_dr(3, 16'b011, 16'b110, "R1 tlr bypass");

      // R7 asynchronous reset restores chain 3
      scan_ir(4'b0010);
      scan_dr(4, 16'h0001, 16'h0008, "R5 ssr capture");
      check(chain_sel == 6'b000010, "R6 chain1", chain_sel, 6'b000010);
      #2 trst_n = 1'b0;
      #3;
      check(chain_sel == 6'b001000, "R7 trst chain", chain_sel, 6'b001000);
      #3 trst_n = 1'b1;
      tick(0, 0);
      scan_dr(2, 16'b01, 16'b10, "R7 trst bypass");

      tick(0, 0);
      check(expq.size() == 0, "R11 all bits seen", expq.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule